// File: doc/BRIEF.md
# DMA Request Serializer with Grant Tracker

The block sits on the request side of an expansion agent that forwards up to eight legacy DMA requests to a host controller. The host has only one shared, active-low request line for this. The block registers the DMA request inputs into a pending vector. Whenever that vector is non-zero, it shifts out a frame on the request line that lists every requesting channel. It re-sends the frame each time the pending set changes. The number of idle clocks before the re-sent frame tells the host why it is being sent: one idle clock means new or withdrawn request information, and two idle clocks mean a granted transfer has just finished.

A second machine watches the active-low grant line. It decodes the channel number that the host grants and drives the matching one-hot acknowledge output. When the granted channel's request drops, that machine reports that the transfer is complete. The two machines run concurrently. A grant can be decoded while a request frame is still being shifted out, and a grant can stay active while the request line is idle. Channels used in cascade mode for bus-master requests need no special handling: their requests enter and leave the pending set like any other channel.

Top module: `dreq_serializer`

## Requirements
- R1: A frame is `req_no` low for one start clock, then one clock per channel in order 0 to 7, where a bit is low when that channel is requesting. After the last bit, `req_no` returns high.
- R2: From the idle state with nothing transmitted, a DREQ change applied before clock edge k makes the start clock of a frame appear in the cycle after edge k+1.
- R3: When a pending request drops before any grant, `req_no` stays high for exactly one gap clock. The frame is then re-sent without that channel, with its start clock in the cycle after edge k+2.
- R4: When a new request rises after a frame was sent and no grant is outstanding, the frame is re-sent with the new channel included, using the same one-clock gap and timing as R3.
- R5: `gnt_ni` low for one start clock followed by three channel bits, least significant first, grants a channel. `dack_o` is active high and one-hot at the granted channel position. It is set in the cycle after the last channel bit and held until completion.
- R6: While a grant is outstanding, changes in the other channels' requests cause no re-send, and `req_no` stays high.
- R7: When the granted channel's DREQ deasserts, `xfer_done_o` pulses for one clock and `dack_o` clears, both in the cycle after edge k+1. After exactly two gap clocks, a frame of the still-pending channels starts in the cycle after edge k+3, even if no new request arrived.
- R8: With no channel pending, including right after a completion that leaves nothing pending, `req_no` stays high and no frame is sent.
- R9: A grant that arrives while a frame is being shifted out is decoded normally, and the frame in progress completes unchanged.
- R10: While `rst_ni` is low, `req_no` is high, `dack_o` is zero and `xfer_done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dreq_i | input | 8 | DMA request per channel, active high |
| gnt_ni | input | 1 | Serial grant line from host, active low start |
| req_no | output | 1 | Serial request line to host, active low |
| dack_o | output | 8 | One-hot acknowledge of the granted channel |
| xfer_done_o | output | 1 | One-clock pulse when a granted transfer completes |

## Verification
The serializer is driven with single-channel, multi-channel, edge-channel (0 and 7) and all-channel request sets. Each frame is decoded at the request pin and compared against a queue of expected vectors, which separates bit order and polarity errors from content errors. The start latency is measured for each type of change: first frame, withdrawn request, added request and completed grant. The measured latencies of two, three and four clocks show whether each case selected the correct gap. Request changes made while a grant is held must produce no frame, and a grant is injected in the middle of a frame to show that the two machines do not disturb each other.

// File: rtl/dsr_pkg.sv
`timescale 1ns/1ps
package dsr_pkg;
  typedef enum logic [2:0] {
    R_IDLE  = 3'd0,
    R_GAP   = 3'd1,
    R_START = 3'd2,
    R_BITS  = 3'd3,
    R_SENT  = 3'd4
  } req_state_e;

  typedef enum logic [1:0] {
    G_IDLE = 2'd0,
    G_BITS = 2'd1,
    G_HELD = 2'd2
  } gnt_state_e;
endpackage

// File: rtl/dsr_pend_sync.sv
`timescale 1ns/1ps
module dsr_pend_sync #(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] dreq_i,
  output logic [NUM_CH-1:0] pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= dreq_i;
  end
endmodule

// File: rtl/dsr_gnt_track.sv
`timescale 1ns/1ps
module dsr_gnt_track
  import dsr_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gnt_ni,
  input  logic [NUM_CH-1:0] pend_i,
  output logic [NUM_CH-1:0] dack_o,
  output logic              busy_o,
  output logic              done_evt_o,
  output logic              done_o
);
  gnt_state_e       st_q, st_d;
  logic [CH_W-1:0]  ch_q, ch_d;
  logic [CH_W-1:0]  cnt_q, cnt_d;
  logic             held;

  assign held       = (st_q == G_HELD);
  assign busy_o     = (st_q != G_IDLE);
  assign done_evt_o = held && !pend_i[ch_q];

  always_comb begin
    st_d  = st_q;
    ch_d  = ch_q;
    cnt_d = cnt_q;
    unique case (st_q)
      G_IDLE: if (!gnt_ni) begin
        st_d  = G_BITS;
        cnt_d = '0;
      end
      G_BITS: begin
        ch_d[cnt_q] = gnt_ni;
        if (cnt_q == CH_W'(CH_W - 1)) st_d = G_HELD;
        else                          cnt_d = cnt_q + 1'b1;
      end
      G_HELD: if (done_evt_o) st_d = G_IDLE;
      default: st_d = G_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= G_IDLE;
      ch_q   <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      ch_q   <= ch_d;
      cnt_q  <= cnt_d;
      done_o <= done_evt_o;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dack
    assign dack_o[g] = held && (ch_q == CH_W'(g));
  end
endmodule

// File: rtl/dsr_req_ser.sv
`timescale 1ns/1ps
module dsr_req_ser
  import dsr_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int SHORT_GAP = 1,
  parameter int LONG_GAP  = 2,
  parameter int CNT_W     = $clog2(NUM_CH),
  parameter int GAP_W     = $clog2(LONG_GAP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pend_i,
  input  logic              busy_i,
  input  logic              done_evt_i,
  output logic              req_no,
  output req_state_e        state_o,
  output logic [NUM_CH-1:0] frame_o,
  output logic              long_o
);
  req_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [NUM_CH-1:0] frame_q, frame_d;
  logic [NUM_CH-1:0] sent_q, sent_d;
  logic              long_q, long_d;
  logic              any_pend, want_long;

  assign any_pend  = |pend_i;
  assign want_long = done_evt_i || long_q;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    gap_d   = gap_q;
    frame_d = frame_q;
    sent_d  = sent_q;
    long_d  = want_long;
    unique case (st_q)
      R_IDLE: begin
        if (want_long) begin
          long_d = 1'b0;
          if (any_pend) begin
            st_d  = R_GAP;
            gap_d = GAP_W'(LONG_GAP - 1);
          end
        end else if (any_pend) begin
          st_d    = R_START;
          frame_d = pend_i;
        end
      end
      R_SENT: begin
        if (want_long) begin
          long_d = 1'b0;
          st_d   = R_GAP;
          gap_d  = GAP_W'(LONG_GAP - 1);
        end else if (!busy_i && (pend_i != sent_q)) begin
          st_d  = R_GAP;
          gap_d = GAP_W'(SHORT_GAP - 1);
        end
      end
      R_GAP: begin
        if (gap_q == '0) begin
          if (any_pend) begin
            st_d    = R_START;
            frame_d = pend_i;
          end else begin
            st_d   = R_IDLE;
            sent_d = '0;
          end
        end else begin
          gap_d = gap_q - 1'b1;
        end
      end
      R_START: begin
        st_d  = R_BITS;
        cnt_d = '0;
      end
      R_BITS: begin
        if (cnt_q == CNT_W'(NUM_CH - 1)) begin
          st_d   = R_SENT;
          sent_d = frame_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = R_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= R_IDLE;
      cnt_q   <= '0;
      gap_q   <= '0;
      frame_q <= '0;
      sent_q  <= '0;
      long_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      gap_q   <= gap_d;
      frame_q <= frame_d;
      sent_q  <= sent_d;
      long_q  <= long_d;
    end
  end

  // low = start clock or a requesting channel bit
  assign req_no  = !((st_q == R_START) || ((st_q == R_BITS) && frame_q[cnt_q]));
  assign state_o = st_q;
  assign frame_o = frame_q;
  assign long_o  = long_q;
endmodule

// File: rtl/dreq_serializer.sv
`timescale 1ns/1ps
module dreq_serializer
  import dsr_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int SHORT_GAP = 1,
  parameter int LONG_GAP  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] dreq_i,
  input  logic              gnt_ni,
  output logic              req_no,
  output logic [NUM_CH-1:0] dack_o,
  output logic              xfer_done_o
);
  localparam int CH_W = $clog2(NUM_CH);

  logic [NUM_CH-1:0] pend;
  logic              gnt_busy;
  logic              done_evt;
  req_state_e        r_state;
  logic [NUM_CH-1:0] r_frame;
  logic              r_long;

  dsr_pend_sync #(.NUM_CH(NUM_CH)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dreq_i (dreq_i),
    .pend_o (pend)
  );

  dsr_gnt_track #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_gnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gnt_ni     (gnt_ni),
    .pend_i     (pend),
    .dack_o     (dack_o),
    .busy_o     (gnt_busy),
    .done_evt_o (done_evt),
    .done_o     (xfer_done_o)
  );

  dsr_req_ser #(
    .NUM_CH    (NUM_CH),
    .SHORT_GAP (SHORT_GAP),
    .LONG_GAP  (LONG_GAP)
  ) u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (pend),
    .busy_i     (gnt_busy),
    .done_evt_i (done_evt),
    .req_no     (req_no),
    .state_o    (r_state),
    .frame_o    (r_frame),
    .long_o     (r_long)
  );
endmodule

// File: rtl/dsr_checker.sv
`timescale 1ns/1ps
module dsr_checker
  import dsr_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] dreq_i,
  input logic              req_no,
  input logic [NUM_CH-1:0] dack_o,
  input logic              xfer_done_o,
  input req_state_e        r_state,
  input logic [NUM_CH-1:0] r_frame,
  input logic              r_long,
  input logic              done_evt
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_IDLE: assert (req_no && (dack_o == '0) && !xfer_done_o); // R10
    end
  end

  AST_DACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dack_o)); // R5

  AST_DONE_AFTER_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |-> (($past(dack_o) != '0) && (($past(dreq_i, 2) & $past(dack_o)) == '0))); // R7

  AST_DONE_CLEARS_DACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |-> (dack_o == '0)); // R7

  AST_START_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_state == R_START) |-> (r_frame != '0)); // R8

  AST_NO_RESEND_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((r_state == R_SENT) && (dack_o != '0) && !done_evt && !r_long) |=> (r_state == R_SENT)); // R6

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_state == R_START) |-> !req_no); // R1
endmodule

bind dreq_serializer dsr_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dreq_i      (dreq_i),
  .req_no      (req_no),
  .dack_o      (dack_o),
  .xfer_done_o (xfer_done_o),
  .r_state     (r_state),
  .r_frame     (r_frame),
  .r_long      (r_long),
  .done_evt    (done_evt)
);

// File: tb/dreq_serializer_tb.sv
`timescale 1ns/1ps
module dreq_serializer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] dreq = '0;
  logic       gnt_n = 1'b1;
  logic       req_n;
  logic [7:0] dack;
  logic       done;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  logic       done_at2;
  logic [7:0] dack_at2;

  always #2.5 clk = ~clk;

  dreq_serializer dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .dreq_i      (dreq),
    .gnt_ni      (gnt_n),
    .req_no      (req_n),
    .dack_o      (dack),
    .xfer_done_o (done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: decode frames on req_n and compare against scoreboard
  initial begin
    bit         in_frame = 0;
    int         idx = 0;
    logic [7:0] got = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!in_frame) begin
          if (!req_n) begin
            in_frame = 1;
            idx = 0;
            got = '0;
          end
        end else begin
          got[idx] = ~req_n;
          idx++;
          if (idx == 8) begin
            in_frame = 0;
            if (exp_q.size() == 0) chk("R1 unexpected frame", {24'd0, got}, 32'hdead);
            else chk("R1 frame content", {24'd0, got}, {24'd0, exp_q.pop_front()});
          end
        end
      end
    end
  end

  // drive a DREQ change, queue the expected frame and measure start latency
  task automatic change_expect(input logic [7:0] v, input logic [7:0] frame,
                               input int lat, input string tag);
    int n;
    @(negedge clk);
    dreq = v;
    exp_q.push_back(frame);
    n = 0;
    done_at2 = 1'b0;
    dack_at2 = 'x;
    do begin
      @(negedge clk);
      n++;
      if (n == 2) begin
        done_at2 = done;
        dack_at2 = dack;
      end
    end while (req_n && n < 40);
    chk(tag, n, lat);
  endtask

  task automatic grant(input logic [2:0] ch);
    @(negedge clk);
    gnt_n = 1'b0;
    for (int b = 0; b < 3; b++) begin
      @(negedge clk);
      gnt_n = ch[b];
    end
    @(negedge clk);
    gnt_n = 1'b1;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string tag);
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!req_n) lows++;
    end
    chk(tag, lows, 0);
  endtask

  initial begin
    int dn;
    wait_n(3);
    chk("R10 reset req", {31'd0, req_n}, 1);
    chk("R10 reset dack", {24'd0, dack}, 0);
    chk("R10 reset done", {31'd0, done}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    quiet(20, "R8 idle no frame");

    change_expect(8'h06, 8'h06, 2, "R2 first frame latency");
    wait_n(10);
    change_expect(8'h04, 8'h04, 3, "R3 drop resend latency");
    wait_n(10);
    change_expect(8'h0C, 8'h0C, 3, "R4 new request latency");
    wait_n(10);

    grant(3'd3);
    chk("R5 dack ch3", {24'd0, dack}, 32'h08);
    @(negedge clk);
    dreq = 8'h0D;
    quiet(14, "R6 change ignored while granted");
    chk("R6 dack held", {24'd0, dack}, 32'h08);

    change_expect(8'h05, 8'h05, 4, "R7 completion long gap latency");
    chk("R7 done pulse", {31'd0, done_at2}, 1);
    chk("R7 dack cleared", {24'd0, dack_at2}, 0);
    wait_n(10);

    change_expect(8'h45, 8'h45, 3, "R4 add ch6 latency");
    grant(3'd6);
    chk("R9 grant during frame", {24'd0, dack}, 32'h40);
    wait_n(8);
    chk("R9 frame intact", exp_q.size(), 0);
    change_expect(8'h05, 8'h05, 4, "R7 resend remaining");
    wait_n(10);

    change_expect(8'h01, 8'h01, 3, "R3 drop ch2");
    wait_n(10);
    grant(3'd0);
    chk("R5 dack ch0", {24'd0, dack}, 32'h01);
    @(negedge clk);
    dreq = 8'h00;
    dn = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done) dn++;
      if (!req_n) dn += 100;
    end
    chk("R8 done no frame after last", dn, 1);

    change_expect(8'h80, 8'h80, 2, "R2 ch7 from idle");
    wait_n(10);
    change_expect(8'hFF, 8'hFF, 3, "R4 all channels");
    wait_n(10);
    grant(3'd7);
    chk("R5 dack ch7", {24'd0, dack}, 32'h80);
    change_expect(8'h7F, 8'h7F, 4, "R7 ch7 completion");
    wait_n(12);
    chk("R1 scoreboard empty", exp_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule